// File: doc/BRIEF.md
# Miss-Correlation Prefetcher

This block watches the stream of cache-miss addresses and learns, for each miss address, which addresses have tended to miss right after it. A direct-mapped table, indexed by the low bits of a miss address and tagged with the remaining bits, keeps four successor candidates per entry. Each candidate carries a small saturating confidence count.

On every miss the block does two things. It looks up the current address and queues every stored successor with a non-zero confidence for prefetch. It also trains the entry of the previous miss so that the current address is recorded as one of that entry's successors. Prefetch requests leave the block one per cycle, highest confidence first. Each requested address is also recorded in a small fully associative prefetch buffer. The cache queries that buffer through a lookup port, and a query that hits consumes the entry.

Top module: `miss_corr_prefetcher`

## Requirements
- R1: After reset, pf_valid is 0, every buffer lookup misses, and the first misses produce no prefetch requests, because the table holds no valid entries.
- R2: The table has 64 entries. The index is miss_addr[5:0] and the tag is miss_addr[15:6]. On each miss after the first, the previous miss's entry is trained with the current address. If that entry is invalid or holds a different tag, it is overwritten: the new tag is stored, the current address goes into slot 0 with confidence 1, and all other slots are cleared to confidence 0.
- R3: If the current address already sits in a slot with non-zero confidence, that confidence rises by 1 and saturates at 3. The other slots are unchanged.
- R4: If the current address is not already a candidate, it replaces the slot with the lowest confidence, with ties going to the lowest slot number, and takes confidence 1. Every other slot with non-zero confidence drops by 1.
- R5: On a miss whose entry is valid with a matching tag, pf_valid rises in the cycle after the miss. It stays high for one cycle per candidate with non-zero confidence, presenting those candidates in descending confidence order, with ties in ascending slot order. Candidates with confidence 0 are never requested.
- R6: The lookup for a miss sees the table as it was before that same miss's training is applied.
- R7: A miss whose entry is invalid, or whose tag does not match, produces no prefetch requests.
- R8: A new miss cancels any requests still pending from the previous miss. The queue is reloaded from the new lookup in the same cycle.
- R9: Each cycle with pf_valid high inserts pf_addr into the 16-entry prefetch buffer, unless that address is already present. Insertions take slots in ring order, so the 17th insertion evicts the address written by the 1st.
- R10: lk_hit is high in the same cycle that lk_valid is high with an address held in the buffer. That entry is removed at the following clock edge, so a repeated lookup of the same address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| miss_valid | input | 1 | A demand miss is presented this cycle |
| miss_addr | input | 16 | Line address of the demand miss |
| pf_valid | output | 1 | A prefetch request is presented this cycle |
| pf_addr | output | 16 | Line address to prefetch |
| lk_valid | input | 1 | The cache queries the prefetch buffer this cycle |
| lk_addr | input | 16 | Address queried in the prefetch buffer |
| lk_hit | output | 1 | The queried address is held in the buffer (same cycle) |

## Verification
Errors in the table become visible at the ports on the next miss to the trained address. Such errors include a wrong victim slot, missing aging, a wrapping confidence counter, or a tag that is not replaced. They show up one cycle after that miss, as a changed request count or order on pf_valid and pf_addr. The stimulus therefore revisits each trained address soon after training it, and arranges confidence ties, zero-confidence slots and saturation so that each rule changes the request sequence. Errors in the buffer, such as a duplicate insertion, a removal that did not happen, or the wrong eviction slot, appear on lk_hit at the very next lookup of the affected address.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_IDX_W  = 6;
  localparam int unsigned DEF_NCAND  = 4;
  localparam int unsigned DEF_CONF_W = 2;
  localparam int unsigned DEF_PBUF_N = 16;
endpackage

// File: rtl/mcp_table.sv
module mcp_table #(
  parameter int unsigned ADDR_W = mcp_pkg::DEF_ADDR_W,
  parameter int unsigned IDX_W  = mcp_pkg::DEF_IDX_W,
  parameter int unsigned NCAND  = mcp_pkg::DEF_NCAND,
  parameter int unsigned CONF_W = mcp_pkg::DEF_CONF_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             miss_valid,
  input  logic [ADDR_W-1:0]                miss_addr,
  output logic                             rd_hit,
  output logic [NCAND-1:0][ADDR_W-1:0]     rd_cand,
  output logic [NCAND-1:0][CONF_W-1:0]     rd_conf
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned TAG_W   = ADDR_W - IDX_W;
  localparam int unsigned SLOT_W  = (NCAND > 1) ? $clog2(NCAND) : 1;
  localparam logic [CONF_W-1:0] CMAX = '1;

  logic [ENTRIES-1:0]                   ent_vld;
  logic [TAG_W-1:0]                     ent_tag  [ENTRIES];
  logic [NCAND-1:0][ADDR_W-1:0]         ent_cand [ENTRIES];
  logic [NCAND-1:0][CONF_W-1:0]         ent_conf [ENTRIES];

  logic              prev_valid;
  logic [ADDR_W-1:0] prev_addr;

  logic [IDX_W-1:0]  ri, wi;
  logic              tr_en, t_match, found;
  logic [SLOT_W-1:0] mslot, vslot;
  logic [CONF_W-1:0] vconf;
  logic [NCAND-1:0][ADDR_W-1:0] old_c, n_c;
  logic [NCAND-1:0][CONF_W-1:0] old_f, n_f;

  // lookup reads state before this miss's training
  assign ri      = miss_addr[IDX_W-1:0];
  assign rd_hit  = ent_vld[ri] && (ent_tag[ri] == miss_addr[ADDR_W-1:IDX_W]);
  assign rd_cand = ent_cand[ri];
  assign rd_conf = ent_conf[ri];

  assign wi    = prev_addr[IDX_W-1:0];
  assign tr_en = miss_valid && prev_valid;

  always_comb begin
    old_c   = ent_cand[wi];
    old_f   = ent_conf[wi];
    t_match = ent_vld[wi] && (ent_tag[wi] == prev_addr[ADDR_W-1:IDX_W]);
    found   = 1'b0;
    mslot   = '0;
    for (int c = 0; c < NCAND; c++) begin
      if (!found && old_f[c] != '0 && old_c[c] == miss_addr) begin
        found = 1'b1;
        mslot = SLOT_W'(c);
      end
    end
    vslot = '0;
    vconf = old_f[0];
    for (int c = 1; c < NCAND; c++) begin
      if (old_f[c] < vconf) begin
        vconf = old_f[c];
        vslot = SLOT_W'(c);
      end
    end
    n_c = old_c;
    n_f = old_f;
    if (!t_match) begin
      n_c    = '0;
      n_f    = '0;
      n_c[0] = miss_addr;
      n_f[0] = CONF_W'(1);
    end else if (found) begin
      if (old_f[mslot] != CMAX) n_f[mslot] = old_f[mslot] + CONF_W'(1);
    end else begin
      for (int c = 0; c < NCAND; c++) begin
        if (SLOT_W'(c) == vslot) begin
          n_c[c] = miss_addr;
          n_f[c] = CONF_W'(1);
        end else if (old_f[c] != '0) begin
          n_f[c] = old_f[c] - CONF_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld    <= '0;
      prev_valid <= 1'b0;
      prev_addr  <= '0;
    end else if (miss_valid) begin
      prev_valid <= 1'b1;
      prev_addr  <= miss_addr;
      if (tr_en) ent_vld[wi] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tr_en) begin
      ent_tag[wi]  <= prev_addr[ADDR_W-1:IDX_W];
      ent_cand[wi] <= n_c;
      ent_conf[wi] <= n_f;
    end
  end

  function automatic int unsigned nz_count(input logic [NCAND-1:0][CONF_W-1:0] f);
    int unsigned k;
    k = 0;
    for (int c = 0; c < NCAND; c++) if (f[c] != '0) k++;
    return k;
  endfunction

  // R2: a freshly allocated entry carries exactly one live candidate
  a_r2_alloc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tr_en && !t_match |=> nz_count(ent_conf[$past(wi)]) == 1);

  // R3: a saturated candidate that is seen again stays saturated
  a_r3_conf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    tr_en && t_match && found && old_f[mslot] == CMAX
      |=> ent_conf[$past(wi)][$past(mslot)] == CMAX);
endmodule

// File: rtl/mcp_rank.sv
module mcp_rank #(
  parameter int unsigned ADDR_W = mcp_pkg::DEF_ADDR_W,
  parameter int unsigned NCAND  = mcp_pkg::DEF_NCAND,
  parameter int unsigned CONF_W = mcp_pkg::DEF_CONF_W,
  localparam int unsigned CNT_W = $clog2(NCAND + 1)
) (
  input  logic [NCAND-1:0][ADDR_W-1:0] cand,
  input  logic [NCAND-1:0][CONF_W-1:0] conf,
  output logic [NCAND-1:0][ADDR_W-1:0] ord_addr,
  output logic [CNT_W-1:0]             ord_cnt
);
  logic [CNT_W-1:0] rank [NCAND];

  // rank = number of candidates that must go before this one
  always_comb begin
    ord_cnt = '0;
    for (int i = 0; i < NCAND; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NCAND; j++) begin
        if (conf[j] > conf[i] || (conf[j] == conf[i] && j < i))
          rank[i] = rank[i] + CNT_W'(1);
      end
      if (conf[i] != '0) ord_cnt = ord_cnt + CNT_W'(1);
    end
    ord_addr = '0;
    for (int r = 0; r < NCAND; r++) begin
      for (int i = 0; i < NCAND; i++) begin
        if (rank[i] == CNT_W'(r)) ord_addr[r] = cand[i];
      end
    end
  end
endmodule

// File: rtl/mcp_pbuf.sv
module mcp_pbuf #(
  parameter int unsigned ADDR_W = mcp_pkg::DEF_ADDR_W,
  parameter int unsigned DEPTH  = mcp_pkg::DEF_PBUF_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit
);
  localparam int unsigned WP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld, vld_n, lk_match;
  logic [ADDR_W-1:0] adr [DEPTH];
  logic [WP_W-1:0]   wp, wp_n;
  logic              present, do_push;

  always_comb begin
    present  = 1'b0;
    lk_match = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && adr[i] == push_addr) present = 1'b1;
      lk_match[i] = vld[i] && adr[i] == lk_addr;
    end
    lk_hit  = lk_valid && (|lk_match);
    do_push = push && !present;
    vld_n   = vld;
    if (lk_valid) vld_n = vld & ~lk_match;
    wp_n = wp;
    if (do_push) begin
      vld_n[wp] = 1'b1;
      wp_n      = (wp == WP_W'(DEPTH - 1)) ? '0 : wp + WP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      wp  <= '0;
    end else begin
      vld <= vld_n;
      wp  <= wp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) adr[wp] <= push_addr;
  end

  function automatic logic holds(input logic [ADDR_W-1:0] a);
    logic h;
    h = 1'b0;
    for (int i = 0; i < DEPTH; i++) if (vld[i] && adr[i] == a) h = 1'b1;
    return h;
  endfunction

  // R10: a consumed address is gone after the edge
  a_r10_hit_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && !(push && push_addr == lk_addr) |=> !holds($past(lk_addr)));

  // R9: pushing an address already held does not grow the buffer
  a_r9_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    push && holds(push_addr) && !lk_valid |=> $countones(vld) == $past($countones(vld)));
endmodule

// File: rtl/miss_corr_prefetcher.sv
module miss_corr_prefetcher #(
  parameter int unsigned ADDR_W = mcp_pkg::DEF_ADDR_W,
  parameter int unsigned IDX_W  = mcp_pkg::DEF_IDX_W,
  parameter int unsigned NCAND  = mcp_pkg::DEF_NCAND,
  parameter int unsigned CONF_W = mcp_pkg::DEF_CONF_W,
  parameter int unsigned PBUF_N = mcp_pkg::DEF_PBUF_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit
);
  localparam int unsigned CNT_W = $clog2(NCAND + 1);
  localparam int unsigned PTR_W = (NCAND > 1) ? $clog2(NCAND) : 1;

  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic                         rd_hit;
  logic [NCAND-1:0][ADDR_W-1:0] rd_cand, ord_addr;
  logic [NCAND-1:0][CONF_W-1:0] rd_conf;
  logic [CNT_W-1:0]             ord_cnt;

  mcp_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NCAND(NCAND), .CONF_W(CONF_W)) table_i (
    .clk(clk), .rst_n(rst_q_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .rd_hit(rd_hit), .rd_cand(rd_cand), .rd_conf(rd_conf)
  );

  mcp_rank #(.ADDR_W(ADDR_W), .NCAND(NCAND), .CONF_W(CONF_W)) rank_i (
    .cand(rd_cand), .conf(rd_conf), .ord_addr(ord_addr), .ord_cnt(ord_cnt)
  );

  logic [NCAND-1:0][ADDR_W-1:0] q_addr, q_addr_n;
  logic [CNT_W-1:0]             q_cnt, q_cnt_n, q_ptr, q_ptr_n;

  assign pf_valid = (q_ptr < q_cnt);
  assign pf_addr  = q_addr[q_ptr[PTR_W-1:0]];

  always_comb begin
    q_addr_n = q_addr;
    q_cnt_n  = q_cnt;
    q_ptr_n  = q_ptr;
    if (miss_valid) begin
      q_addr_n = ord_addr;
      q_cnt_n  = rd_hit ? ord_cnt : '0;
      q_ptr_n  = '0;
    end else if (pf_valid) begin
      q_ptr_n = q_ptr + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      q_cnt <= '0;
      q_ptr <= '0;
    end else begin
      q_cnt <= q_cnt_n;
      q_ptr <= q_ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_valid) q_addr <= q_addr_n;
  end

  mcp_pbuf #(.ADDR_W(ADDR_W), .DEPTH(PBUF_N)) pbuf_i (
    .clk(clk), .rst_n(rst_q_n), .push(pf_valid), .push_addr(pf_addr),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit)
  );

  // R7: a miss without a matching entry leaves the request port idle
  a_r7_tagmiss_silent: assert property (@(posedge clk) disable iff (!rst_q_n)
    miss_valid && !rd_hit |=> !pf_valid);
endmodule

// File: tb/miss_corr_prefetcher_tb.sv
module miss_corr_prefetcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic [15:0] miss_addr;
  logic        pf_valid;
  logic [15:0] pf_addr;
  logic        lk_valid;
  logic [15:0] lk_addr;
  logic        lk_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  miss_corr_prefetcher dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0]      a;
    logic [2:0]       n;
    logic [0:3][15:0] e;
  } vec_t;

  // A=0101 B=0202 C=0303 D=0404 X=4101 (same index as A, other tag)
  localparam vec_t VEC [19] = '{
    {16'h0101, 3'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'h0202, 3'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd1, 16'h0202, 16'h0000, 16'h0000, 16'h0000},
    {16'h0202, 3'd1, 16'h0101, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd1, 16'h0202, 16'h0000, 16'h0000, 16'h0000},
    {16'h0303, 3'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd2, 16'h0202, 16'h0303, 16'h0000, 16'h0000},
    {16'h0303, 3'd1, 16'h0101, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd2, 16'h0303, 16'h0202, 16'h0000, 16'h0000},
    {16'h0404, 3'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd2, 16'h0303, 16'h0404, 16'h0000, 16'h0000},
    {16'h4101, 3'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd1, 16'h4101, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd1, 16'h0101, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd1, 16'h0101, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd1, 16'h0101, 16'h0000, 16'h0000, 16'h0000},
    {16'h0202, 3'd1, 16'h0101, 16'h0000, 16'h0000, 16'h0000},
    {16'h0101, 3'd2, 16'h0101, 16'h0202, 16'h0000, 16'h0000}
  };

  localparam string VTAG [19] = '{
    "R1", "R7", "R2 R5", "R2 R5", "R3 R5", "R4 R7", "R4 R5", "R3 R5", "R3 R5", "R4 R7",
    "R4 R5", "R4 R7", "R6 R5", "R2 R6", "R2 R3", "R3", "R3", "R5", "R3 R4"
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_miss(input logic [15:0] a, output int n, output logic [0:3][15:0] g);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
    n = 0;
    g = '0;
    for (int i = 0; i < 4; i++) begin
      if (pf_valid) begin
        if (n < 4) g[n] = pf_addr;
        n++;
      end
      if (i < 3) @(negedge clk);
    end
  endtask

  task automatic do_lookup(input logic [15:0] a, output logic hit);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = a;
    #1 hit = lk_hit;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [0:3][15:0] g;
    logic h;
    bit ok;
    miss_valid = 1'b0;
    miss_addr  = '0;
    lk_valid   = 1'b0;
    lk_addr    = '0;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(pf_valid == 1'b0, "R1 pf_valid after reset", int'(pf_valid), 0);
    do_lookup(16'h0202, h);
    chk(h == 1'b0, "R1 empty buffer lookup", int'(h), 0);

    // table walk: training, ranking, tag handling
    for (int v = 0; v < 19; v++) begin
      do_miss(VEC[v].a, n, g);
      ok = (n == int'(VEC[v].n));
      for (int i = 0; i < 4; i++) if (i < n && i < int'(VEC[v].n) && g[i] != VEC[v].e[i]) ok = 1'b0;
      chk(ok, VTAG[v], (n << 16) | int'(g[0]), (int'(VEC[v].n) << 16) | int'(VEC[v].e[0]));
    end

    // R8: a second miss right behind the first cancels the remaining request
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = 16'h0101;
    @(negedge clk);
    miss_addr  = 16'h0505;
    chk(pf_valid && pf_addr == 16'h0101, "R8 first request issued", int'(pf_addr), 16'h0101);
    @(negedge clk);
    miss_valid = 1'b0;
    chk(pf_valid == 1'b0, "R8 remaining request dropped", int'(pf_valid), 0);
    repeat (4) @(negedge clk);
    chk(pf_valid == 1'b0, "R8 port stays idle", int'(pf_valid), 0);

    // R10 / R9: buffer holds B A C D X, each once
    do_lookup(16'h0303, h);
    chk(h == 1'b1, "R10 lookup hit", int'(h), 1);
    do_lookup(16'h0303, h);
    chk(h == 1'b0, "R10 consumed entry misses", int'(h), 0);
    do_lookup(16'h0101, h);
    chk(h == 1'b1, "R9 repeated address held", int'(h), 1);
    do_lookup(16'h0101, h);
    chk(h == 1'b0, "R9 no duplicate copy", int'(h), 0);
    do_lookup(16'h7777, h);
    chk(h == 1'b0, "R10 never-requested address", int'(h), 0);
    do_lookup(16'h4101, h);
    chk(h == 1'b1, "R10 lookup hit second address", int'(h), 1);

    // R9: ring eviction with 20 distinct requests
    do_reset();
    chk(pf_valid == 1'b0, "R1 pf_valid after second reset", int'(pf_valid), 0);
    for (int k = 0; k < 20; k++) begin
      do_miss(16'h1000 + 16'(k), n, g);
      if (k == 0 || k == 19) chk(n == 0, "R1 untrained miss silent", n, 0);
    end
    for (int k = 0; k < 20; k++) begin
      do_miss(16'h1000 + 16'(k), n, g);
      if (k == 0 || k == 19)
        chk(n == 1 && g[0] == 16'h1000 + 16'((k + 1) % 20), "R2 chain successor",
            int'(g[0]), 16'h1000 + ((k + 1) % 20));
    end
    do_lookup(16'h1001, h);
    chk(h == 1'b0, "R9 oldest insertion evicted", int'(h), 0);
    do_lookup(16'h1004, h);
    chk(h == 1'b0, "R9 fourth insertion evicted", int'(h), 0);
    do_lookup(16'h1005, h);
    chk(h == 1'b1, "R9 fifth insertion kept", int'(h), 1);
    do_lookup(16'h1000, h);
    chk(h == 1'b1, "R9 newest insertion kept", int'(h), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule